// File: doc/BRIEF.md
# Set/Clear Aliased Control Register

This block holds one control word that firmware can change bit by bit without reading it first. The word is reached at two bus offsets. A write to the set offset turns on every bit that carries a 1 in the write data. A write to the clear offset turns off every bit that carries a 1 in the write data. Bits that carry a 0 keep their value in both cases. Each change therefore takes a single write, and two agents that touch different bits cannot undo each other's work.

The block sits on a simple synchronous register bus with one address, a write enable, write data, a read enable and registered read data. A read of either offset returns the whole stored word. The stored word also drives a parallel output to downstream logic. No other offset is decoded. Writes to any other offset change nothing, and reads of any other offset return zero.

Top module: `setclr_alias_reg`

## Requirements
- R1: On a rising clock edge with `rst_n` low, the stored word becomes 0x00000000 and `bus_rdata` becomes zero.
- R2: A write (`bus_wr_en` high) at offset 0x20 sets to 1 each stored bit whose write-data bit is 1. Stored bits whose write-data bit is 0 keep their value.
- R3: A write at offset 0x24 clears to 0 each stored bit whose write-data bit is 1. Stored bits whose write-data bit is 0 keep their value.
- R4: A read (`bus_rd_en` high) at offset 0x20 or 0x24 returns the full stored word on `bus_rdata` in the cycle after the read edge. If a write happens at the same edge, the read returns the word as it was before that write.
- R5: A write at any offset other than 0x20 and 0x24 leaves the stored word unchanged. A read at such an offset returns zero. The whole address is compared, so partial matches such as 0x21 do not hit.
- R6: In the cycle after an edge where `bus_rd_en` is low, `bus_rdata` is zero.
- R7: `ctrl_o` always equals the stored word. A write shows on `ctrl_o` in the cycle after its clock edge, and back-to-back writes apply in order.
- R8: Start with only bits 0 and 7 set (0x00000081). Write 0x00000004 at the set offset, then write 0x00000020 at the clear offset. The stored word then reads 0x00000085.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data, used as a per-bit mask |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid one cycle after the read |
| ctrl_o | output | 32 | Stored word, driven to downstream logic |

## Verification
The bench builds the block with its default parameters: a 32-bit word, an 8-bit offset, the set offset at 0x20 and the clear offset at 0x24. The full 32-bit width lets patterns that touch both the upper and lower halves at once show any bit that is lost or crosses to another position. The 8-bit offset lets the bench aim at nearby unused offsets (0x21, 0x28, 0x00) to check that the decode compares every address bit. Because both offsets are parameters, a swapped or shared decode shows up as a wrong value on `ctrl_o` or `bus_rdata`.

// File: rtl/setclr_pkg.sv
package setclr_pkg;

    // Kind of register access selected by the address decode.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2
    } acc_e;

endpackage

// File: rtl/setclr_decode.sv
module setclr_decode
    import setclr_pkg::*;
#(
    parameter int unsigned          ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]    SET_OFS = 8'h20,
    parameter logic [ADDR_W-1:0]    CLR_OFS = 8'h24
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_e              kind
);

    // Full-width compare; every address bit must match.
    always_comb begin
        if (addr == SET_OFS) begin
            kind = ACC_SET;
        end else if (addr == CLR_OFS) begin
            kind = ACC_CLR;
        end else begin
            kind = ACC_NONE;
        end
    end

endmodule

// File: rtl/setclr_update.sv
module setclr_update
    import setclr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  acc_e              kind,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] nxt
);

    logic set_sel;
    logic clr_sel;

    assign set_sel = (kind == ACC_SET);
    assign clr_sel = (kind == ACC_CLR);

    // One slice per stored bit: a masked set wins to 1, a masked clear to 0.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic set_b;
        logic clr_b;
        assign set_b = set_sel & mask[i];
        assign clr_b = clr_sel & mask[i];
        assign nxt[i] = set_b ? 1'b1 : (clr_b ? 1'b0 : cur[i]);
    end

endmodule

// File: rtl/setclr_rdmux.sv
module setclr_rdmux
    import setclr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              rd_en,
    input  acc_e              kind,
    input  logic [DATA_W-1:0] store,
    output logic [DATA_W-1:0] rdata_nxt
);

    logic hit;

    assign hit = rd_en && (kind != ACC_NONE);

    // Both aliases return the same word; misses and idle cycles give zero.
    always_comb begin
        rdata_nxt = '0;
        if (hit) begin
            rdata_nxt = store;
        end
    end

endmodule

// File: rtl/setclr_alias_reg.sv
module setclr_alias_reg
    import setclr_pkg::*;
#(
    parameter int unsigned          DATA_W  = 32,
    parameter int unsigned          ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]    SET_OFS = 8'h20,
    parameter logic [ADDR_W-1:0]    CLR_OFS = 8'h24,
    parameter logic [DATA_W-1:0]    RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd_en,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ctrl_o
);

    typedef struct packed {
        logic [DATA_W-1:0] store;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t            st_d;
    state_t            st_q;
    acc_e              addr_kind;
    acc_e              wr_kind;
    logic [DATA_W-1:0] store_nxt;
    logic [DATA_W-1:0] rdata_nxt;

    setclr_decode #(
        .ADDR_W  (ADDR_W),
        .SET_OFS (SET_OFS),
        .CLR_OFS (CLR_OFS)
    ) u_decode (
        .addr (bus_addr),
        .kind (addr_kind)
    );

    assign wr_kind = bus_wr_en ? addr_kind : ACC_NONE;

    setclr_update #(
        .DATA_W (DATA_W)
    ) u_update (
        .kind (wr_kind),
        .cur  (st_q.store),
        .mask (bus_wdata),
        .nxt  (store_nxt)
    );

    // The read samples the word before any write at the same edge.
    setclr_rdmux #(
        .DATA_W (DATA_W)
    ) u_rdmux (
        .rd_en     (bus_rd_en),
        .kind      (addr_kind),
        .store     (st_q.store),
        .rdata_nxt (rdata_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.store = store_nxt;
        st_d.rdata = rdata_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.store <= RST_VAL;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o    = st_q.store;
    assign bus_rdata = st_q.rdata;

    AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == SET_OFS) |=> ((ctrl_o & $past(bus_wdata)) == $past(bus_wdata))); // R2
    AST_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == SET_OFS) |=> ((ctrl_o & ~$past(bus_wdata)) == ($past(ctrl_o) & ~$past(bus_wdata)))); // R2
    AST_CLR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == CLR_OFS) |=> ((ctrl_o & $past(bus_wdata)) == '0)); // R3
    AST_CLR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == CLR_OFS) |=> ((ctrl_o & ~$past(bus_wdata)) == ($past(ctrl_o) & ~$past(bus_wdata)))); // R3
    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_en || (bus_addr != SET_OFS && bus_addr != CLR_OFS)) |=> $stable(ctrl_o)); // R5
    AST_RD_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && (bus_addr == SET_OFS || bus_addr == CLR_OFS)) |=> (bus_rdata == $past(ctrl_o))); // R4
    AST_RD_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr != SET_OFS && bus_addr != CLR_OFS) |=> (bus_rdata == '0)); // R5
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_en) |=> (bus_rdata == '0)); // R6

endmodule

// File: tb/setclr_alias_reg_tb.sv
module setclr_alias_reg_tb;

    localparam int unsigned DW = 32;
    localparam int unsigned AW = 8;
    localparam logic [AW-1:0] A_SET = 8'h20;
    localparam logic [AW-1:0] A_CLR = 8'h24;

    typedef struct {
        logic [DW-1:0] val;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr_en = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_rd_en = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] ctrl_o;

    int            n_chk = 0;
    int            n_err = 0;
    logic [DW-1:0] model = '0;
    exp_t          exp_q[$];
    logic          rd_seen = 1'b0;
    logic          mon_on = 1'b0;

    always #4 clk = ~clk;

    setclr_alias_reg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rd_en (bus_rd_en),
        .bus_rdata (bus_rdata),
        .ctrl_o    (ctrl_o)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] apply(input logic [AW-1:0] a, input logic [DW-1:0] d,
                                            input logic [DW-1:0] cur);
        if (a == A_SET) return cur | d;
        if (a == A_CLR) return cur & ~d;
        return cur;
    endfunction

    function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
        return (a == A_SET || a == A_CLR) ? model : '0;
    endfunction

    // Driver: every task drives one bus cycle, 2 ns after the rising edge.
    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #2;
        bus_wr_en = 1'b1; bus_rd_en = 1'b0; bus_addr = a; bus_wdata = d;
        model = apply(a, d, model);
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input string tag);
        exp_t e;
        @(posedge clk); #2;
        bus_wr_en = 1'b0; bus_rd_en = 1'b1; bus_addr = a; bus_wdata = '0;
        e.val = peek(a); e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic bus_wr_rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        exp_t e;
        @(posedge clk); #2;
        bus_wr_en = 1'b1; bus_rd_en = 1'b1; bus_addr = a; bus_wdata = d;
        e.val = peek(a); e.tag = tag;
        exp_q.push_back(e);
        model = apply(a, d, model);
    endtask

    task automatic bus_idle();
        @(posedge clk); #2;
        bus_wr_en = 1'b0; bus_rd_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    // Monitor: rd_en seen before edge N is answered at the negedge after edge N.
    always @(negedge clk) begin
        if (mon_on) begin
            if (rd_seen) begin
                if (exp_q.size() == 0) begin
                    check("R4 unexpected read result", bus_rdata, 32'hDEAD_BEEF);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, bus_rdata, e.val);
                end
            end else begin
                check("R6 idle read data", bus_rdata, '0);
            end
        end
        rd_seen = bus_rd_en;
    end

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset ctrl_o", ctrl_o, '0);
        check("R1 reset rdata", bus_rdata, '0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        bus_rd(A_SET, "R1 read after reset");
        bus_wr(A_SET, 32'h0000_0081);
        bus_idle();
        check("R2 set 0x81", ctrl_o, 32'h0000_0081);
        check("R7 ctrl_o follows", ctrl_o, model);
        bus_rd(A_SET, "R4 read set alias");
        bus_rd(A_CLR, "R4 read clear alias");

        bus_wr(A_SET, 32'h0000_0004);
        bus_wr(A_CLR, 32'h0000_0020);
        bus_idle();
        check("R8 example ctrl_o", ctrl_o, 32'h0000_0085);
        bus_rd(A_CLR, "R8 example read");

        bus_wr(A_SET, 32'hFFFF_0000);
        bus_idle();
        check("R2 set upper half", ctrl_o, 32'hFFFF_0085);
        bus_wr(A_CLR, 32'h0F0F_0001);
        bus_idle();
        check("R3 clear mixed", ctrl_o, 32'hF0F0_0084);
        bus_wr(A_SET, 32'h0000_0000);
        bus_wr(A_CLR, 32'h0000_0000);
        bus_idle();
        check("R2 R3 zero mask holds", ctrl_o, 32'hF0F0_0084);

        bus_wr(8'h28, 32'hFFFF_FFFF);
        bus_wr(8'h21, 32'hFFFF_FFFF);
        bus_wr(8'h00, 32'hFFFF_FFFF);
        bus_wr(8'hA4, 32'hFFFF_FFFF);
        bus_idle();
        check("R5 stray writes ignored", ctrl_o, 32'hF0F0_0084);
        bus_rd(8'h28, "R5 stray read 0x28");
        bus_rd(8'h21, "R5 stray read 0x21");
        bus_rd(A_SET, "R5 value intact");

        bus_wr_rd(A_CLR, 32'hFFFF_FFFF, "R4 read before same-edge write");
        bus_idle();
        check("R3 clear all", ctrl_o, '0);
        bus_wr_rd(A_SET, 32'hA5A5_5A5A, "R4 read old word");
        bus_rd(A_SET, "R4 read new word");
        bus_idle();
        check("R7 ctrl_o after set", ctrl_o, 32'hA5A5_5A5A);

        bus_wr(A_CLR, 32'h8000_0001);
        bus_wr(A_SET, 32'h0000_0001);
        bus_wr(A_CLR, 32'hA000_0000);
        bus_idle();
        check("R7 back-to-back order", ctrl_o, 32'h05A5_5A5B);

        bus_wr(A_SET, 32'h1234_5678);
        @(posedge clk); #2;
        rst_n = 1'b0; bus_wr_en = 1'b0;
        @(posedge clk); #2;
        check("R1 reset clears word", ctrl_o, '0);
        rst_n = 1'b1;
        model = '0;
        bus_rd(A_CLR, "R1 read after second reset");
        bus_idle();
        bus_idle();
        if (exp_q.size() != 0) check("R4 pending reads", 32'(exp_q.size()), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule